// File: doc/BRIEF.md
# Configurable Lookup-Table RAM

This block is a tiny memory built from two 16-entry, one-bit storage arrays, in the style of the lookup-table RAM inside a programmable logic cell. A two-bit mode input regroups the same 32 bits of storage in one of three ways. The first is a 16x2 single-port memory. The second is a 32x1 single-port memory. The third is a 16x1 memory with one write port and two read ports.

Writes take effect on the rising clock edge when the write enable is high. The write address is decoded one-of-16 inside each array, so a write touches exactly one entry. Reads need no clock: each output is a 16-to-1 selection driven by an address.

Initial contents come from two parameters and are loaded only at start-up. No input clears the storage. The mode may change only in a cycle where the write enable is low.

Top module: `lutram_cfg`

## Requirements
- R1: Mode encoding: `mode`=0 is 16x2 single-port, 1 is 32x1 single-port, 2 is 16x1 dual-port, and 3 behaves exactly as 0.
- R2: In 16x2 mode, a rising edge with `we`=1 stores `din[0]` into entry `waddr[3:0]` of the low array and `din[1]` into the same entry of the high array. `waddr[4]` is ignored.
- R3: In 16x2 mode, `dout[0]` shows low-array entry `waddr[3:0]` and `dout[1]` shows high-array entry `waddr[3:0]`, both combinationally.
- R4: In 32x1 mode, a write stores `din[0]` at entry `waddr[3:0]` of the array chosen by `waddr[4]`: 0 chooses the low array and 1 the high array. The other array is left unchanged.
- R5: In 32x1 mode, `dout[0]` shows entry `waddr[3:0]` of the array chosen by `waddr[4]`, and `dout[1]` is 0.
- R6: In dual-port mode, a write stores `din[0]` into entry `waddr[3:0]` of both arrays. `din[1]` is ignored.
- R7: In dual-port mode, `dout[0]` shows low-array entry `waddr[3:0]` and `dout[1]` shows high-array entry `raddr`.
- R8: With `we`=0, a clock edge changes no entry.
- R9: A read of the entry being written returns the old value until the edge and the new value after it.
- R10: Entry i of the low and high arrays starts as bit i of `INIT_LO` and `INIT_HI`. Both parameters default to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| mode | input | 2 | Arrangement select (see R1) |
| we | input | 1 | Write enable |
| waddr | input | 5 | Write/read address; bit 4 used only in 32x1 mode |
| raddr | input | 4 | Second read address, dual-port mode only |
| din | input | 2 | Write data; bit 1 used only in 16x2 mode |
| dout | output | 2 | Asynchronous read data |

## Verification
Random writes and reads in every mode are compared against a two-array bench model. Mixing modes on the same storage reveals whether the 32x1 bank select or the dual-port double write lands in the wrong array. Directed sweeps check the initial image under a non-zero parameter, so a swapped or reversed bit order shows up. A write followed by a read of the same entry, sampled before and after the edge, separates a transparent array from a proper edge-written one. Writes with `we` low, and dual-port writes with `din[1]` opposite to `din[0]`, show that the ignored inputs truly leave the contents alone.

// File: rtl/lutram_cfg.sv
module lutram_cfg #(
  parameter int ABITS = 4,
  parameter logic [(1<<ABITS)-1:0] INIT_LO = '0,
  parameter logic [(1<<ABITS)-1:0] INIT_HI = '0
) (
  input  logic             clk,
  input  logic [1:0]       mode,
  input  logic             we,
  input  logic [ABITS:0]   waddr,
  input  logic [ABITS-1:0] raddr,
  input  logic [1:0]       din,
  output logic [1:0]       dout
);
  localparam int DEPTH = 1 << ABITS;
  localparam logic [1:0] M_DEEP = 2'd1;
  localparam logic [1:0] M_DUAL = 2'd2;

  logic [DEPTH-1:0] mem_lo = INIT_LO;
  logic [DEPTH-1:0] mem_hi = INIT_HI;

  wire [ABITS-1:0] idx  = waddr[ABITS-1:0];
  wire             bank = waddr[ABITS];
  wire             deep = (mode == M_DEEP);
  wire             dual = (mode == M_DUAL);

  wire [DEPTH-1:0] hot    = DEPTH'(1) << idx;
  wire             en_lo  = we & ~(deep & bank);
  wire             en_hi  = we & ~(deep & ~bank);
  wire             bit_lo = din[0];
  wire             bit_hi = (deep | dual) ? din[0] : din[1];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (en_lo && hot[i]) mem_lo[i] <= bit_lo;
      if (en_hi && hot[i]) mem_hi[i] <= bit_hi;
    end
  end

  wire rd_lo   = mem_lo[idx];
  wire rd_hi_w = mem_hi[idx];
  wire rd_hi_r = mem_hi[raddr];

  assign dout[0] = (deep && bank) ? rd_hi_w : rd_lo;
  assign dout[1] = deep ? 1'b0 : (dual ? rd_hi_r : rd_hi_w);
endmodule

// File: rtl/lutram_cfg_chk.sv
module lutram_cfg_chk #(
  parameter int ABITS = 4
) (
  input logic             clk,
  input logic [1:0]       mode,
  input logic             we,
  input logic [ABITS:0]   waddr,
  input logic [ABITS-1:0] raddr,
  input logic [1:0]       din,
  input logic [1:0]       dout
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_wide_write_r2: assert property (@(posedge clk) disable iff (!armed)
    ($past(we) && $past(mode) == 2'd0 && mode == 2'd0 && $stable(waddr))
      |-> dout == $past(din));

  p_deep_write_r4: assert property (@(posedge clk) disable iff (!armed)
    ($past(we) && $past(mode) == 2'd1 && mode == 2'd1 && $stable(waddr))
      |-> dout[0] == $past(din[0]));

  p_deep_upper_r5: assert property (@(posedge clk) disable iff (!armed)
    (mode == 2'd1) |-> dout[1] == 1'b0);

  p_dual_write_r6: assert property (@(posedge clk) disable iff (!armed)
    ($past(we) && $past(mode) == 2'd2 && mode == 2'd2 && $stable(waddr)
     && raddr == $past(waddr[ABITS-1:0]))
      |-> dout == {2{$past(din[0])}});

  p_hold_r8: assert property (@(posedge clk) disable iff (!armed)
    (!$past(we) && $stable(waddr) && $stable(raddr) && $stable(mode))
      |-> $stable(dout));
endmodule

bind lutram_cfg lutram_cfg_chk #(.ABITS(ABITS)) u_chk (.*);

// File: tb/sim_lutram_cfg.sv
module sim_lutram_cfg;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] mode = 2'd0;
  logic       we = 1'b0;
  logic [4:0] waddr = '0;
  logic [3:0] raddr = '0;
  logic [1:0] din = '0;
  logic [1:0] dout;

  logic [4:0] a1 = '0;
  logic [1:0] dout1;

  localparam logic [15:0] IL = 16'hA5C3;
  localparam logic [15:0] IH = 16'h0F69;

  lutram_cfg u0 (.clk(clk), .mode(mode), .we(we), .waddr(waddr),
                 .raddr(raddr), .din(din), .dout(dout));

  lutram_cfg #(.INIT_LO(IL), .INIT_HI(IH)) u1 (.clk(clk), .mode(2'd0),
                 .we(1'b0), .waddr(a1), .raddr(4'd0), .din(2'd0), .dout(dout1));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] ref_lo = '0;
  logic [15:0] ref_hi = '0;

  function automatic logic [1:0] model(input logic [1:0] m, input logic [4:0] wa,
                                       input logic [3:0] ra);
    logic [3:0] i;
    i = wa[3:0];
    case (m)
      2'd1:    return {1'b0, wa[4] ? ref_hi[i] : ref_lo[i]};
      2'd2:    return {ref_hi[ra], ref_lo[i]};
      default: return {ref_hi[i], ref_lo[i]};
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b mode=%0d waddr=%h raddr=%h",
               tag, act, exp, mode, waddr, raddr);
    end
  endtask

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd1:    return "R5 32x1 read";
      2'd2:    return "R7 dual read";
      default: return "R3 16x2 read";
    endcase
  endfunction

  task automatic step(input logic [1:0] m, input logic w, input logic [4:0] wa,
                      input logic [3:0] ra, input logic [1:0] d);
    logic [3:0] i;
    @(negedge clk);
    mode = m; we = w; waddr = wa; raddr = ra; din = d;
    #1 check(tag_of(m), dout, model(m, wa, ra));
    @(posedge clk);
    i = wa[3:0];
    if (w) begin
      case (m)
        2'd1:    if (wa[4]) ref_hi[i] = d[0]; else ref_lo[i] = d[0];
        2'd2:    begin ref_lo[i] = d[0]; ref_hi[i] = d[0]; end
        default: begin ref_lo[i] = d[0]; ref_hi[i] = d[1]; end
      endcase
    end
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      mode = 2'd0; we = 1'b0; waddr = 5'(k); raddr = 4'(k);
      #1 check(tag, dout, {ref_hi[k], ref_lo[k]});
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] m;
    logic [1:0] mprev;
    // R10 reset state: default parameters give zeros; u1 carries its init image
    sweep("R10 default zero");
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      a1 = 5'(k);
      #1 check("R10 init image", dout1, {IH[k], IL[k]});
    end

    // R2 16x2 writes, waddr[4] ignored
    step(2'd0, 1, 5'h13, 0, 2'b10);
    step(2'd0, 0, 5'h03, 0, 2'b00);
    check("R2 upper addr bit ignored", dout, 2'b10);
    // R9 read during write: old value before the edge, new after
    step(2'd0, 1, 5'h03, 0, 2'b01);
    step(2'd0, 0, 5'h03, 0, 2'b00);
    check("R9 new after edge", dout, 2'b01);

    // R4 32x1 bank select leaves other array untouched
    step(2'd1, 0, 5'h05, 0, 0);
    step(2'd1, 1, 5'h15, 0, 2'b01);
    step(2'd1, 0, 5'h05, 0, 0);
    check("R4 low array untouched", dout, 2'b00);
    step(2'd1, 0, 5'h15, 0, 0);
    check("R4 high array written", dout, 2'b01);

    // R6 dual writes both arrays, din[1] ignored
    step(2'd2, 0, 5'h07, 4'h7, 0);
    step(2'd2, 1, 5'h07, 4'h7, 2'b10);
    step(2'd2, 0, 5'h07, 4'h7, 0);
    check("R6 din1 ignored", dout, 2'b00);
    step(2'd2, 1, 5'h08, 4'h7, 2'b01);
    step(2'd2, 0, 5'h01, 4'h8, 0);
    check("R6 both arrays", dout[1], 1'b1);

    // R8 writes with we low change nothing
    for (int k = 0; k < 16; k++) step(2'd0, 0, 5'(k), 0, ~2'(k));
    sweep("R8 we low no change");

    // R1 mode 3 behaves as 16x2
    step(2'd3, 0, 5'h0A, 0, 0);
    step(2'd3, 1, 5'h0A, 0, 2'b10);
    sweep("R1 mode3 as 16x2");

    // random mix
    void'($urandom(32'd1234));
    mprev = 2'd0;
    for (int n = 0; n < 3000; n++) begin
      logic w;
      m = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 2) != 0) && (m == mprev);
      step(m, w, 5'($urandom), 4'($urandom), 2'($urandom));
      mprev = m;
    end
    sweep("R2 R4 R6 random image");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule